// File: doc/BRIEF.md
# Dual Flash Read Page Buffer

This block sits between a CPU read port and a slow page-mode nonvolatile memory array. It keeps two 32-byte line buffers. The choice of buffer depends on the kind of access and not on the address: one buffer keeps the line of the latest instruction fetch and the other keeps the line of the latest data read. When a read arrives, its line address (the address without its five low bits) is compared with the tag of the buffer for that access type. On a match, the word chosen by address bits [4:2] comes back from the buffer without touching the array. On a mismatch, the block asks the array for the whole line. It waits a variable number of cycles for the line, stores it in the buffer for that access type and returns the addressed word.

Reads are refused while the module is in reset, disabled, stopped, or while high voltage is applied to the array and not suspended. A refused read completes with an error flag and zero data, and it leaves the buffers alone. Six event inputs mark a loss of coherency, such as program writes, erase interlock writes or changes to the suspend controls. Any of them drops both buffers, so the next read of each type must go to the array. Only one array fetch is in flight at a time.

Top module: `flash_rdbuf`

## Requirements
- R1: The instruction buffer (req_instr=1) and the data buffer (req_instr=0) are independent: a miss of one type never replaces or invalidates the line held for the other type.
- R2: A read whose line address matches the valid buffer of its type is answered one cycle after acceptance with rsp_valid=1, rsp_err=0 and the addressed word, and raises no array request.
- R3: A read that misses holds arr_req high with arr_line_addr equal to req_addr[31:5] until arr_line_valid. One cycle after arr_line_valid it answers with the word at index req_addr[4:2] of the returned line (word i at bits [32i+31:32i]), and later reads of that line hit.
- R4: A read accepted while mod_disable, mod_stop or hv_active is high is answered one cycle later with rsp_err=1 and rsp_data=0. It raises no array request and leaves both buffers and their valid bits unchanged.
- R5: While rst is high, req_ready, rsp_valid and arr_req are low. After rst is released, both buffers are invalid.
- R6: A one-cycle pulse on any bit of inv_evt invalidates both buffers, so the next read of each type misses. The bits are [0] suspend control changed, [1] program write, [2] erase interlock write, [3] high-voltage start, [4] setup bit cleared, [5] suspend-interrupt enable changed.
- R7: An inv_evt pulse in the same cycle that a read is accepted makes that read a miss, even when its line was held.
- R8: An inv_evt pulse while a miss is outstanding still forwards the returned word, but the line is not kept valid and the next read of it misses.
- R9: From the acceptance of a miss until its response cycle, req_ready is low, so at most one array fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_err | output | 1 | Read was refused |
| rsp_data | output | 32 | Read word, zero when refused |
| mod_disable | input | 1 | Module disabled |
| mod_stop | input | 1 | Module in stop mode |
| hv_active | input | 1 | High voltage applied and not suspended |
| inv_evt | input | 6 | Coherency-breaking event pulses |
| arr_req | output | 1 | Array line fetch request |
| arr_line_addr | output | 27 | Line address of the fetch |
| arr_line_valid | input | 1 | Array line returned this cycle |
| arr_line_data | input | 256 | Returned line |

## Verification
Invalidation can fall in the same cycle as a lookup, or in the same cycle as an outstanding line returns. The bench pulses an inv_evt bit together with an accepted request to a held line and expects a miss with correct data. It also pulses an event inside a slow fetch and expects the word to be forwarded, followed by a second miss on the same line. The fetch count from the bench's array model and the returned words decide both cases.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;
    parameter int ADDR_W     = 32;
    parameter int WORD_W     = 32;
    parameter int LINE_WORDS = 8;
    parameter int INV_W      = 6;
    parameter int NUM_BUF    = 2;

    localparam int LINE_BYTES = LINE_WORDS * WORD_W / 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BSEL_W     = $clog2(WORD_W / 8);
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int TAG_W      = ADDR_W - OFF_W;
    localparam int LINE_W     = LINE_WORDS * WORD_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {BUF_DATA = 1'b0, BUF_INSTR = 1'b1} buf_kind_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} state_e;

    typedef struct packed {
        tag_t      tag;
        wsel_t     wsel;
        buf_kind_e kind;
    } req_t;

    typedef struct packed {
        logic  valid;
        logic  err;
        word_t data;
    } rsp_t;

    function automatic req_t split_addr(input logic [ADDR_W-1:0] a, input logic instr);
        req_t r;
        r.tag  = a[ADDR_W-1:OFF_W];
        r.wsel = a[OFF_W-1:BSEL_W];
        r.kind = buf_kind_e'(instr);
        return r;
    endfunction

    function automatic word_t pick_word(input line_t l, input wsel_t w);
        return l[int'(w)*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/rdbuf_line.sv
module rdbuf_line
    import rdbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  inv_i,
    input  logic  load_i,
    input  logic  load_vld_i,
    input  tag_t  load_tag_i,
    input  line_t load_data_i,
    output logic  vld_o,
    output tag_t  tag_o,
    output line_t data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else if (load_i) begin
            vld_o <= load_vld_i;
        end else if (inv_i) begin
            vld_o <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            tag_o  <= load_tag_i;
            data_o <= load_data_i;
        end
    end
endmodule

// File: rtl/rdbuf_ctrl.sv
module rdbuf_ctrl
    import rdbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid_i,
    output logic      req_ready_o,
    input  req_t      req_i,
    input  logic      refuse_i,
    input  logic      hit_i,
    input  word_t     hit_word_i,
    input  logic      inv_i,
    output logic      arr_req_o,
    output tag_t      arr_tag_o,
    input  logic      arr_line_valid_i,
    input  line_t     arr_line_data_i,
    output logic      ld_en_o,
    output buf_kind_e ld_kind_o,
    output logic      ld_vld_o,
    output rsp_t      rsp_o
);
    state_e state_q;
    req_t   pend_q;
    logic   taint_q;
    logic   accept;

    assign req_ready_o = (state_q == ST_IDLE) && !rst;
    assign accept      = req_valid_i && req_ready_o;
    assign arr_req_o   = (state_q == ST_FETCH);
    assign arr_tag_o   = pend_q.tag;
    assign ld_en_o     = (state_q == ST_FETCH) && arr_line_valid_i;
    assign ld_kind_o   = pend_q.kind;
    assign ld_vld_o    = !(taint_q || inv_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            taint_q <= 1'b0;
            rsp_o   <= '0;
        end else begin
            rsp_o <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (refuse_i) begin
                            rsp_o.valid <= 1'b1;
                            rsp_o.err   <= 1'b1;
                        end else if (hit_i) begin
                            rsp_o.valid <= 1'b1;
                            rsp_o.data  <= hit_word_i;
                        end else begin
                            pend_q  <= req_i;
                            taint_q <= 1'b0;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    taint_q <= taint_q || inv_i;
                    if (arr_line_valid_i) begin
                        rsp_o.valid <= 1'b1;
                        rsp_o.data  <= pick_word(arr_line_data_i, pend_q.wsel);
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_rdbuf.sv
module flash_rdbuf
    import rdbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_instr,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data,
    input  logic              mod_disable,
    input  logic              mod_stop,
    input  logic              hv_active,
    input  logic [INV_W-1:0]  inv_evt,
    output logic              arr_req,
    output logic [TAG_W-1:0]  arr_line_addr,
    input  logic              arr_line_valid,
    input  logic [LINE_W-1:0] arr_line_data
);
    req_t      cur_req;
    logic      inv_any;
    logic      refuse;
    logic      lookup_hit;
    word_t     hit_word;
    logic      ld_en;
    buf_kind_e ld_kind;
    logic      ld_vld;
    rsp_t      rsp;

    logic  buf_vld  [NUM_BUF];
    tag_t  buf_tag  [NUM_BUF];
    line_t buf_data [NUM_BUF];

    assign cur_req = split_addr(req_addr, req_instr);
    assign inv_any = |inv_evt;
    assign refuse  = mod_disable || mod_stop || hv_active;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        rdbuf_line u_line (
            .clk         (clk),
            .rst         (rst),
            .inv_i       (inv_any),
            .load_i      (ld_en && (int'(ld_kind) == g)),
            .load_vld_i  (ld_vld),
            .load_tag_i  (arr_line_addr),
            .load_data_i (arr_line_data),
            .vld_o       (buf_vld[g]),
            .tag_o       (buf_tag[g]),
            .data_o      (buf_data[g])
        );
    end

    assign lookup_hit = buf_vld[cur_req.kind] && (buf_tag[cur_req.kind] == cur_req.tag) && !inv_any;
    assign hit_word   = pick_word(buf_data[cur_req.kind], cur_req.wsel);

    rdbuf_ctrl u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .req_valid_i      (req_valid),
        .req_ready_o      (req_ready),
        .req_i            (cur_req),
        .refuse_i         (refuse),
        .hit_i            (lookup_hit),
        .hit_word_i       (hit_word),
        .inv_i            (inv_any),
        .arr_req_o        (arr_req),
        .arr_tag_o        (arr_line_addr),
        .arr_line_valid_i (arr_line_valid),
        .arr_line_data_i  (arr_line_data),
        .ld_en_o          (ld_en),
        .ld_kind_o        (ld_kind),
        .ld_vld_o         (ld_vld),
        .rsp_o            (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_err   = rsp.err;
    assign rsp_data  = rsp.data;
endmodule

// File: rtl/rdbuf_chk.sv
module rdbuf_chk
    import rdbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mod_disable,
    input logic              mod_stop,
    input logic              hv_active,
    input logic              lookup_hit,
    input logic              arr_req,
    input logic              arr_line_valid,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [WORD_W-1:0] rsp_data
);
    a_r4_refused: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (mod_disable || mod_stop || hv_active))
        |=> (rsp_valid && rsp_err && !arr_req));

    a_r4_err_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_data == '0));

    a_r2_hit_fast: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lookup_hit && !mod_disable && !mod_stop && !hv_active)
        |=> (rsp_valid && !rsp_err && !arr_req));

    a_r3_hold_req: assert property (@(posedge clk) disable iff (rst)
        (arr_req && !arr_line_valid) |=> arr_req);

    a_r3_line_rsp: assert property (@(posedge clk) disable iff (rst)
        (arr_req && arr_line_valid) |=> (rsp_valid && !rsp_err && !arr_req));

    a_r9_single_fetch: assert property (@(posedge clk) disable iff (rst)
        arr_req |-> !req_ready);
endmodule

bind flash_rdbuf rdbuf_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mod_disable    (mod_disable),
    .mod_stop       (mod_stop),
    .hv_active      (hv_active),
    .lookup_hit     (lookup_hit),
    .arr_req        (arr_req),
    .arr_line_valid (arr_line_valid),
    .rsp_valid      (rsp_valid),
    .rsp_err        (rsp_err),
    .rsp_data       (rsp_data)
);

// File: tb/tb_flash_rdbuf.sv
`timescale 1ns/1ps
module tb_flash_rdbuf;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_instr = 1'b0;
    logic         rsp_valid, rsp_err;
    logic [31:0]  rsp_data;
    logic         mod_disable = 1'b0, mod_stop = 1'b0, hv_active = 1'b0;
    logic [5:0]   inv_evt = '0;
    logic         arr_req;
    logic [26:0]  arr_line_addr;
    logic         arr_line_valid;
    logic [255:0] arr_line_data;

    int n_checks = 0;
    int n_errors = 0;
    int lat = 2;
    int fetch_cnt = 0;
    logic [26:0] last_line;
    int cnt;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_rdbuf dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_instr(req_instr), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .mod_disable(mod_disable),
        .mod_stop(mod_stop), .hv_active(hv_active), .inv_evt(inv_evt),
        .arr_req(arr_req), .arr_line_addr(arr_line_addr),
        .arr_line_valid(arr_line_valid), .arr_line_data(arr_line_data)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_1E0F;
    endfunction

    function automatic logic [255:0] mkline(input logic [26:0] t);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = pat({t, w[2:0], 2'b00});
        return l;
    endfunction

    // array model
    always @(posedge clk) begin
        if (rst) begin
            arr_line_valid <= 1'b0;
            arr_line_data  <= '0;
            cnt            <= 0;
        end else if (arr_line_valid) begin
            arr_line_valid <= 1'b0;
            fetch_cnt      <= fetch_cnt + 1;
        end else if (arr_req) begin
            if (cnt >= lat) begin
                arr_line_valid <= 1'b1;
                arr_line_data  <= mkline(arr_line_addr);
                last_line      <= arr_line_addr;
                cnt            <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge
    task automatic do_read(input logic [31:0] a, input logic instr, input logic [5:0] inv_same,
                           input int inv_at, output logic [31:0] d, output logic e,
                           output int nf, output bit rdy_hi);
        int f0;
        int c;
        f0 = fetch_cnt;
        req_addr = a; req_instr = instr; req_valid = 1'b1; inv_evt = inv_same;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; inv_evt = '0;
        c = 0; rdy_hi = 0;
        while (!rsp_valid && c < 200) begin
            if (req_ready) rdy_hi = 1;
            c++;
            inv_evt = (c == inv_at) ? 6'b000010 : 6'b0;
            @(negedge clk);
        end
        inv_evt = '0;
        d = rsp_data; e = rsp_err;
        nf = fetch_cnt - f0;
    endtask

    task automatic rd_expect(input logic [31:0] a, input logic instr, input int exp_nf, input string tag);
        logic [31:0] d; logic e; int nf; bit rh;
        do_read(a, instr, 6'b0, -1, d, e, nf, rh);
        chk(d == pat(a) && !e, {tag, " data"}, {31'b0, e, d}, {32'b0, pat(a)});
        chk(nf == exp_nf, {tag, " fetches"}, nf, exp_nf);
    endtask

    task automatic pulse_inv(input logic [5:0] b);
        inv_evt = b;
        @(negedge clk);
        inv_evt = '0;
        @(negedge clk);
    endtask

    // {addr, instr, expected miss}
    localparam logic [33:0] VEC [12] = '{
        {32'h0000_1000, 1'b0, 1'b1},
        {32'h0000_1004, 1'b0, 1'b0},
        {32'h0000_101C, 1'b0, 1'b0},
        {32'h0000_2008, 1'b1, 1'b1},
        {32'h0000_1010, 1'b0, 1'b0},
        {32'h0000_2000, 1'b1, 1'b0},
        {32'h0000_1000, 1'b1, 1'b1},
        {32'h0000_1018, 1'b0, 1'b0},
        {32'h0000_2004, 1'b1, 1'b1},
        {32'h0000_3000, 1'b0, 1'b1},
        {32'h0000_1000, 1'b0, 1'b1},
        {32'h0000_2010, 1'b1, 1'b0}
    };

    initial begin
        logic [31:0] d; logic e; int nf; bit rh;
        // R5 reset state
        repeat (3) @(negedge clk);
        chk(!req_ready && !rsp_valid && !arr_req, "R5 outputs in reset",
            {req_ready, rsp_valid, arr_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R5 ready after reset", req_ready, 1);

        // R1 R2 R3 vector walk
        foreach (VEC[i]) begin
            rd_expect(VEC[i][33:2], VEC[i][1], int'(VEC[i][0]),
                      VEC[i][0] ? "R3 miss vector" : "R1 R2 hit vector");
        end

        // R3 line address and R9 single outstanding fetch with slow array
        lat = 6;
        do_read(32'h0000_A014, 1'b0, 6'b0, -1, d, e, nf, rh);
        chk(last_line == 27'h0000_A014 >> 5, "R3 line address", last_line, 27'h0000_A014 >> 5);
        chk(d == pat(32'h0000_A014), "R3 word select", d, pat(32'h0000_A014));
        chk(!rh, "R9 ready low during miss", rh, 0);
        lat = 2;

        // R4 refusals keep buffers intact
        rd_expect(32'h0000_4000, 1'b0, 1, "R4 prime");
        hv_active = 1'b1;
        do_read(32'h0000_4004, 1'b0, 6'b0, -1, d, e, nf, rh);
        chk(e && d == 0 && nf == 0, "R4 hv refused", {e, d, nf[7:0]}, {1'b1, 40'h0});
        hv_active = 1'b0; mod_disable = 1'b1;
        do_read(32'h0000_5000, 1'b1, 6'b0, -1, d, e, nf, rh);
        chk(e && d == 0 && nf == 0, "R4 disable refused", {e, d, nf[7:0]}, {1'b1, 40'h0});
        mod_disable = 1'b0; mod_stop = 1'b1;
        do_read(32'h0000_4008, 1'b0, 6'b0, -1, d, e, nf, rh);
        chk(e && d == 0 && nf == 0, "R4 stop refused", {e, d, nf[7:0]}, {1'b1, 40'h0});
        mod_stop = 1'b0;
        rd_expect(32'h0000_4008, 1'b0, 0, "R4 buffer kept after refusal");

        // R6 each event bit invalidates both buffers
        for (int b = 0; b < 6; b++) begin
            rd_expect(32'h0000_6000, 1'b0, (b == 0) ? 1 : 0, "R6 data prime");
            rd_expect(32'h0000_7000, 1'b1, (b == 0) ? 1 : 0, "R6 instr prime");
            pulse_inv(6'b1 << b);
            rd_expect(32'h0000_6004, 1'b0, 1, "R6 data after event");
            rd_expect(32'h0000_7004, 1'b1, 1, "R6 instr after event");
        end

        // R7 event in the same cycle as a lookup
        rd_expect(32'h0000_8000, 1'b0, 1, "R7 prime");
        rd_expect(32'h0000_8000, 1'b0, 0, "R7 held");
        do_read(32'h0000_800C, 1'b0, 6'b010000, -1, d, e, nf, rh);
        chk(nf == 1 && d == pat(32'h0000_800C), "R7 same-cycle miss", {nf[7:0], d},
            {8'd1, pat(32'h0000_800C)});

        // R8 event during an outstanding miss
        lat = 6;
        do_read(32'h0000_9000, 1'b1, 6'b0, 2, d, e, nf, rh);
        chk(nf == 1 && d == pat(32'h0000_9000) && !e, "R8 forwarded", {nf[7:0], d},
            {8'd1, pat(32'h0000_9000)});
        lat = 2;
        rd_expect(32'h0000_9004, 1'b1, 1, "R8 not kept");
        rd_expect(32'h0000_9008, 1'b1, 0, "R8 refill kept");

        // R5 reset clears buffers
        rst = 1'b1;
        @(negedge clk);
        chk(!req_ready && !arr_req, "R5 ready low in reset", {req_ready, arr_req}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd_expect(32'h0000_9008, 1'b1, 1, "R5 miss after reset");
        rd_expect(32'h0000_800C, 1'b0, 1, "R5 data miss after reset");

        summary();
    end
endmodule